// File: doc/BRIEF.md
# Retire-Stepped Decrementer Interrupt Unit

This unit keeps a down-counting decrementer that moves one step for each instruction the core retires, not for each clock. While the count is nonzero, a retire lowers it by one. When a retire arrives and the count already reads zero, the count stays at zero and the unit raises its interrupt flag. It also takes a snapshot of the current instruction address and the machine state value given with that retire.

One cycle after the flag rises, the unit presents the interrupt-entry results as registered values. The first save register holds the captured instruction address. The second save register holds the captured machine state with a fixed keep-mask applied. A new machine state value is the captured state with a second keep-mask applied. The redirect target is the fixed vector 0x900, and a redirect strobe lasts one cycle. The flag then stays high and the count stays frozen until the core acknowledges. The acknowledge reloads the count with all ones and returns the unit to counting. Priority between interrupt sources, return from the handler and software writes to the count are handled elsewhere.

The control is a three-state machine. IDLE counts retires. ENTER is the single cycle in which the flag is first high and the results are being registered. WAIT holds the flag until the acknowledge arrives. The transitions are as follows:
- IDLE→ENTER is taken on a retire while the count is zero.
- ENTER→WAIT is taken unconditionally on the next cycle.
- WAIT→IDLE is taken on an acknowledge.

Top module: `dec_irq_unit`

## Requirements
- R1: After reset the count reads all ones (for DEC_W bits), the interrupt flag is low and the redirect strobe is low.
- R2: In IDLE, each cycle with the retire input high and a nonzero count lowers the count by exactly one by the next cycle. A cycle without a retire leaves the count unchanged.
- R3: In IDLE, a retire while the count is zero raises the interrupt flag in the next cycle, and the count stays at zero.
- R4: Exactly one cycle after the flag rises, the redirect strobe is high for exactly one cycle and the redirect PC output reads 64'h900.
- R5: The first save register presents the PC input sampled in the cycle of the retire that found the count at zero. PC values on other cycles do not affect it.
- R6: The second save register presents the machine state sampled with that retire, ANDed with 64'hFFFF_FFFF_78FC_0FFF.
- R7: The new machine state output presents that sampled machine state ANDed with 64'hFFFF_FFFF_FFFF_76CD.
- R8: While the flag is high and no accepted acknowledge occurs, the flag stays high and the count does not change, even with retires.
- R9: An acknowledge in WAIT reloads the count to all ones and lowers the flag by the next cycle. A retire in that same cycle is not counted.
- R10: An acknowledge while in IDLE, or during the ENTER cycle, has no effect on the count or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One instruction retired this cycle |
| pc_i | input | 64 | Address of the current instruction |
| msr_i | input | 64 | Current machine state value |
| ack_i | input | 1 | Core has taken the interrupt |
| irq_o | output | 1 | Decrementer interrupt pending |
| redirect_o | output | 1 | One-cycle strobe: redirect PC and save values valid |
| redirect_pc_o | output | 64 | Interrupt vector address |
| srr0_o | output | 64 | Saved instruction address |
| srr1_o | output | 64 | Saved, masked machine state |
| msr_new_o | output | 64 | Machine state to install on entry |
| dec_o | output | DEC_W | Current decrementer count |

## Verification
A retire changes the count, and it is seen one cycle after the retire is driven. The interrupt flag is due one cycle after the retire that finds zero. The redirect strobe and the save values are due one cycle after that. The reload and the falling flag are due one cycle after the accepted acknowledge. The bench drives inputs on the falling edge and samples outputs on the falling edge that follows the intended rising edge. Each check is placed on exactly that edge. Expected save values are queued by the driver when the zero-retire is issued, and a monitor pops them on the single cycle the redirect strobe is high.

// File: rtl/dec_irq_pkg.sv
package dec_irq_pkg;

    localparam int XLEN = 64;

    localparam logic [XLEN-1:0] SRR1_KEEP_MASK = 64'hFFFF_FFFF_78FC_0FFF;
    localparam logic [XLEN-1:0] MSR_KEEP_MASK  = 64'hFFFF_FFFF_FFFF_76CD;
    localparam logic [XLEN-1:0] DEC_VECTOR     = 64'h0000_0000_0000_0900;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTER = 2'd1,
        ST_WAIT  = 2'd2
    } entry_state_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] msr;
    } entry_snap_t;

endpackage

// File: rtl/dec_counter.sv
module dec_counter #(
    parameter int DEC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             reload_i,
    output logic [DEC_W-1:0] count_o,
    output logic             zero_o
);

    localparam logic [DEC_W-1:0] RELOAD_VAL = {DEC_W{1'b1}};
    localparam logic [DEC_W-1:0] ONE        = DEC_W'(1);

    logic [DEC_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= RELOAD_VAL;
        end else if (reload_i) begin
            count_q <= RELOAD_VAL;
        end else if (step_i && (count_q != '0)) begin
            count_q <= count_q - ONE;
        end
    end

    assign count_o = count_q;
    assign zero_o  = (count_q == '0);

    // R2: a step never wraps the count below zero
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !reload_i) |=> (count_o == '0));

endmodule

// File: rtl/dec_entry_fsm.sv
module dec_entry_fsm
    import dec_irq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         retire_i,
    input  logic         zero_i,
    input  logic         ack_i,
    output entry_state_e state_o,
    output logic         step_o,
    output logic         capture_o,
    output logic         launch_o,
    output logic         reload_o,
    output logic         pending_o
);

    entry_state_e state_q;
    entry_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        step_o    = 1'b0;
        capture_o = 1'b0;
        launch_o  = 1'b0;
        reload_o  = 1'b0;
        pending_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (retire_i) begin
                    if (zero_i) begin
                        capture_o = 1'b1;
                        state_d   = ST_ENTER;
                    end else begin
                        step_o = 1'b1;
                    end
                end
            end
            ST_ENTER: begin
                pending_o = 1'b1;
                launch_o  = 1'b1;
                state_d   = ST_WAIT;
            end
            ST_WAIT: begin
                pending_o = 1'b1;
                if (ack_i) begin
                    reload_o = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign state_o = state_q;

    // R4: the entry cycle lasts exactly one cycle and is followed by WAIT
    a_r4_enter_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER) |=> (state_q == ST_WAIT));

    // R10: an acknowledge during ENTER or IDLE never causes a reload
    a_r10_no_early_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WAIT) |-> !reload_o);

    // R8: the counter is never stepped while an interrupt is outstanding
    a_r8_no_step_pending: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o |-> !step_o);

endmodule

// File: rtl/dec_entry_regs.sv
module dec_entry_regs
    import dec_irq_pkg::*;
#(
    parameter logic [XLEN-1:0] SAVE_MASK = SRR1_KEEP_MASK,
    parameter logic [XLEN-1:0] NEW_MASK  = MSR_KEEP_MASK,
    parameter logic [XLEN-1:0] VECTOR    = DEC_VECTOR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_i,
    input  logic            launch_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] msr_i,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic [XLEN-1:0] srr0_o,
    output logic [XLEN-1:0] srr1_o,
    output logic [XLEN-1:0] msr_new_o
);

    entry_snap_t snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (capture_i) begin
            snap_q.pc  <= pc_i;
            snap_q.msr <= msr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect_o    <= 1'b0;
            redirect_pc_o <= '0;
            srr0_o        <= '0;
            srr1_o        <= '0;
            msr_new_o     <= '0;
        end else begin
            redirect_o <= launch_i;
            if (launch_i) begin
                redirect_pc_o <= VECTOR;
                srr0_o        <= snap_q.pc;
                srr1_o        <= snap_q.msr & SAVE_MASK;
                msr_new_o     <= snap_q.msr & NEW_MASK;
            end
        end
    end

    // R6: masked-off bits of the saved state are always clear when presented
    a_r6_save_mask: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> ((srr1_o & ~SAVE_MASK) == '0));

    // R7: masked-off bits of the new state are always clear when presented
    a_r7_new_mask: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> ((msr_new_o & ~NEW_MASK) == '0));

    // R5: save registers only change on a launch
    a_r5_save_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !launch_i |=> $stable(srr0_o));

endmodule

// File: rtl/dec_irq_unit.sv
module dec_irq_unit
    import dec_irq_pkg::*;
#(
    parameter int DEC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  msr_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic             redirect_o,
    output logic [XLEN-1:0]  redirect_pc_o,
    output logic [XLEN-1:0]  srr0_o,
    output logic [XLEN-1:0]  srr1_o,
    output logic [XLEN-1:0]  msr_new_o,
    output logic [DEC_W-1:0] dec_o
);

    localparam logic [DEC_W-1:0] DEC_ONE = DEC_W'(1);

    entry_state_e state;
    logic         step;
    logic         capture;
    logic         launch;
    logic         reload;
    logic         pending;
    logic         zero;

    dec_counter #(
        .DEC_W (DEC_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .reload_i (reload),
        .count_o  (dec_o),
        .zero_o   (zero)
    );

    dec_entry_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .retire_i  (retire_i),
        .zero_i    (zero),
        .ack_i     (ack_i),
        .state_o   (state),
        .step_o    (step),
        .capture_o (capture),
        .launch_o  (launch),
        .reload_o  (reload),
        .pending_o (pending)
    );

    dec_entry_regs #(
        .SAVE_MASK (SRR1_KEEP_MASK),
        .NEW_MASK  (MSR_KEEP_MASK),
        .VECTOR    (DEC_VECTOR)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture_i     (capture),
        .launch_i      (launch),
        .pc_i          (pc_i),
        .msr_i         (msr_i),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .srr0_o        (srr0_o),
        .srr1_o        (srr1_o),
        .msr_new_o     (msr_new_o)
    );

    assign irq_o = pending;

    // R2: a retire on a nonzero idle count lowers it by one
    a_r2_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && retire_i && (dec_o != '0)) |=> (dec_o == $past(dec_o) - DEC_ONE));

    // R3: a retire on a zero idle count raises the flag and holds zero
    a_r3_zero_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && retire_i && (dec_o == '0)) |=> (irq_o && (dec_o == '0)));

    // R4: the redirect strobe is a single-cycle pulse carrying the vector
    a_r4_redirect_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);
    a_r4_redirect_vec: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (irq_o && (redirect_pc_o == DEC_VECTOR)));

    // R8: without an acknowledge the flag holds and the count is frozen
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> (irq_o && $stable(dec_o)));

    // R9: the flag only falls with the count reloaded to all ones
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> (dec_o == {DEC_W{1'b1}}));

endmodule

// File: tb/sim_dec_irq_unit.sv
module sim_dec_irq_unit;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 6;
    localparam logic [DW-1:0] FULL = {DW{1'b1}};
    localparam logic [63:0] K_SAVE = 64'hFFFF_FFFF_78FC_0FFF;
    localparam logic [63:0] K_NEW  = 64'hFFFF_FFFF_FFFF_76CD;
    localparam logic [63:0] K_VEC  = 64'h900;

    typedef struct {
        logic [63:0] srr0;
        logic [63:0] srr1;
        logic [63:0] msr;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          retire = 1'b0;
    logic          ack = 1'b0;
    logic [63:0]   pc = '0;
    logic [63:0]   msr = '0;
    logic          irq;
    logic          redirect;
    logic [63:0]   redirect_pc;
    logic [63:0]   srr0;
    logic [63:0]   srr1;
    logic [63:0]   msr_new;
    logic [DW-1:0] dec;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dec_irq_unit #(.DEC_W(DW)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .retire_i      (retire),
        .pc_i          (pc),
        .msr_i         (msr),
        .ack_i         (ack),
        .irq_o         (irq),
        .redirect_o    (redirect),
        .redirect_pc_o (redirect_pc),
        .srr0_o        (srr0),
        .srr1_o        (srr1),
        .msr_new_o     (msr_new),
        .dec_o         (dec)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input logic r, input logic a);
        @(negedge clk);
        retire = r;
        ack    = a;
    endtask

    // Monitor: pop an expected entry on each redirect strobe
    logic prev_redirect = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (redirect && prev_redirect) chk("R4 strobe width", 64'd2, 64'd1);
            if (redirect) begin
                if (sb.size() == 0) begin
                    chk("R4 unexpected redirect", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk("R4 vector", redirect_pc, K_VEC);
                    chk("R5 srr0", srr0, e.srr0);
                    chk("R6 srr1", srr1, e.srr1);
                    chk("R7 new msr", msr_new, e.msr);
                end
            end
        end
        prev_redirect = redirect;
    end

    // Driver: one full interrupt episode starting from a zero count
    task automatic fire_round(input logic [63:0] p, input logic [63:0] m);
        exp_t e;
        e.srr0 = p;
        e.srr1 = m & K_SAVE;
        e.msr  = m & K_NEW;
        sb.push_back(e);
        pc  = p;
        msr = m;
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        pc  = ~p;
        msr = ~m;
        chk("R3 flag up", 64'(irq), 64'd1);
        chk("R3 count held", 64'(dec), 64'd0);
        step(1'b1, 1'b0);
        chk("R10 ack in entry ignored", 64'(irq), 64'd1);
        repeat (3) step(1'b1, 1'b0);
        chk("R8 flag held", 64'(irq), 64'd1);
        chk("R8 count frozen", 64'(dec), 64'd0);
        chk("R4 strobe low", 64'(redirect), 64'd0);
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        chk("R9 flag low", 64'(irq), 64'd0);
        chk("R9 reload, retire ignored", 64'(dec), 64'(FULL));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", 64'(dec), 64'(FULL));
        chk("R1 flag", 64'(irq), 64'd0);
        chk("R1 strobe", 64'(redirect), 64'd0);

        for (int i = 0; i < 10; i++) begin
            step(1'b1, 1'b0);
            step(1'b0, 1'b0);
        end
        chk("R2 gapped retires", 64'(dec), 64'(FULL) - 64'd10);
        repeat (3) step(1'b0, 1'b0);
        chk("R2 idle hold", 64'(dec), 64'(FULL) - 64'd10);

        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk("R10 ack idle count", 64'(dec), 64'(FULL) - 64'd10);
        chk("R10 ack idle flag", 64'(irq), 64'd0);

        repeat (int'(FULL) - 10) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R2 reached zero", 64'(dec), 64'd0);
        chk("R3 no flag before check", 64'(irq), 64'd0);

        fire_round(64'h0000_1234_5678_9ABC, 64'hFFFF_FFFF_FFFF_FFFF);

        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R2 count after reload", 64'(dec), 64'(FULL) - 64'd1);

        repeat (int'(FULL) - 1) step(1'b1, 1'b0);
        fire_round(64'hC000_0000_0000_0700, 64'hA5A5_5A5A_F0F0_0F0F);

        repeat (int'(FULL)) step(1'b1, 1'b0);
        fire_round(64'h0000_0000_0000_0004, 64'h0000_0000_8703_F032);

        repeat (4) step(1'b0, 1'b0);
        chk("R4 all redirects seen", 64'(sb.size()), 64'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                chk("watchdog", 64'd1, 64'd0);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule